// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits on the write path of a SECDED-protected memory controller, after the check byte is generated and before the beat goes to the memory. It lets software plant a chosen error in memory. Software loads a control register with an XOR pattern and a writeback flag, then sets an arm bit. The next write beat that passes has the pattern XORed into its check byte. The arm bit clears itself once that beat has gone through. A later read of that location then shows a single-bit (correctable) or double-bit (uncorrectable) error, depending on the pattern.

To plant a correctable error in check bit j, software uses the pattern `1 << j`. To plant one in data bit i, it uses the code's syndrome column for bit i. In both cases it also sets the writeback flag. For an uncorrectable error it uses pattern 0x03 and leaves the writeback flag clear. A busy status bit reports whether writes are queued or still moving through the block, so software can wait for the path to drain before it arms the injector.

Top module: `ecc_wr_injector`

## Requirements
- R1: After reset, the control readback is 0, the status readback is 0 and no output beat is valid.
- R2: The control readback holds the writeback flag at bit 24, the pattern at bits 23:16 and the arm bit at bit 8. All other bits read 0, whatever value was written to them.
- R3: The first write beat accepted while the block is armed leaves with its data unchanged and its check byte equal to the input check byte XOR the pattern. Its inject marker is 1 and its writeback marker equals the stored writeback flag.
- R4: The arm bit reads 0 from the cycle after the injected beat, and later beats carry their check byte unchanged.
- R5: A beat accepted while the block is not armed leaves with its data and check byte unchanged, and its inject and writeback markers are 0.
- R6: When beats arrive on back-to-back cycles after arming, only the first one is modified.
- R7: Status bit 0 (busy) is 1 in any cycle in which the controller reports queued writes, a beat is at the input, or a beat sits in the output stage. Otherwise it is 0.
- R8: A control write with bit 8 clear stores the pattern and flag but does not arm, so the next beat passes unmodified.
- R9: An output beat is valid exactly one cycle after its input beat, for one cycle per input beat.
- R10: If a control write lands in the same cycle as an armed beat, that beat uses the pattern stored before the write, and the newly written value (including its arm bit) is kept.
- R11: Pattern 0x03 with the writeback flag clear flips check bits 0 and 1 of one beat and gives a writeback marker of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register readback |
| stat_rdata | output | 32 | Status readback; bit 0 is busy |
| wq_pending | input | 1 | Controller has write requests queued |
| in_valid | input | 1 | Write beat present at the input |
| in_data | input | DATA_W | Write beat data |
| in_check | input | CHK_W | Check byte computed for the beat |
| out_valid | output | 1 | Write beat present at the output |
| out_data | output | DATA_W | Outgoing data |
| out_check | output | CHK_W | Outgoing check byte, possibly corrupted |
| out_inj | output | 1 | Beat carries an injected pattern |
| out_wb | output | 1 | Writeback flag attached to the injected beat |

## Verification
The bench goes after the one-shot behaviour, because that is where this block is most likely to be wrong.

- If the arm bit failed to clear, a second beat sent back to back would also be corrupted.
- If a write with bit 8 clear armed the block by mistake, a beat that should pass clean would come out modified.
- If a control write and an armed beat landed in the same cycle and the design took the new pattern, or let its self-clear override the fresh arm bit, the two beats that follow would carry the wrong patterns.
- If busy ignored the output stage, it would drop one cycle early.
- If the register field positions were off, the readback of an all-ones write would expose junk bits.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
   // Control register field positions; software depends on these offsets.
   localparam int unsigned CTL_ARM_BIT = 8;
   localparam int unsigned CTL_PAT_LSB = 16;
   localparam int unsigned CTL_WB_BIT  = 24;
   // Status register field positions.
   localparam int unsigned STA_BUSY_BIT = 0;
   // Pattern fields may be at most this wide before colliding with the flag.
   localparam int unsigned PAT_MAX_W = CTL_WB_BIT - CTL_PAT_LSB;
endpackage

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
   import ecc_inj_pkg::*;
#(
   parameter int unsigned REG_W = 32,
   parameter int unsigned CHK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             beat_in,
   output logic             armed,
   output logic [CHK_W-1:0] pat,
   output logic             wb_en,
   output logic             fire,
   output logic [REG_W-1:0] rd_ctl
);
   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata;

   // Injection fires on the first beat seen while armed.
   assign fire = armed & beat_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         pat   <= '0;
         wb_en <= 1'b0;
      end else if (cfg_we) begin
         // A software write wins over the self-clear in the same cycle.
         armed <= cfg_wdata[CTL_ARM_BIT];
         pat   <= cfg_wdata[CTL_PAT_LSB +: CHK_W];
         wb_en <= cfg_wdata[CTL_WB_BIT];
      end else if (fire) begin
         armed <= 1'b0;
      end
   end

   always_comb begin
      rd_ctl                       = '0;
      rd_ctl[CTL_ARM_BIT]          = armed;
      rd_ctl[CTL_PAT_LSB +: CHK_W] = pat;
      rd_ctl[CTL_WB_BIT]           = wb_en;
   end
endmodule

// File: rtl/ecc_inj_lane.sv
module ecc_inj_lane #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned CHK_W   = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CHK_W-1:0]  in_check,
   input  logic              fire,
   input  logic [CHK_W-1:0]  pat,
   input  logic              wb_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [CHK_W-1:0]  out_check,
   output logic              out_inj,
   output logic              out_wb
);
   logic [CHK_W-1:0] flip;
   logic [CHK_W-1:0] chk_n;

   assign flip  = fire ? pat : '0;
   assign chk_n = in_check ^ flip;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_data  <= '0;
               out_check <= '0;
               out_inj   <= 1'b0;
               out_wb    <= 1'b0;
            end else begin
               out_valid <= in_valid;
               out_data  <= in_data;
               out_check <= chk_n;
               out_inj   <= fire;
               out_wb    <= fire & wb_en;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign out_valid  = in_valid;
         assign out_data   = in_data;
         assign out_check  = chk_n;
         assign out_inj    = fire;
         assign out_wb     = fire & wb_en;
      end
   endgenerate
endmodule

// File: rtl/ecc_inj_busy.sv
module ecc_inj_busy
   import ecc_inj_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             wq_pending,
   input  logic             beat_in,
   input  logic             stage_occ,
   output logic             busy,
   output logic [REG_W-1:0] rd_stat
);
   assign busy = wq_pending | beat_in | stage_occ;

   always_comb begin
      rd_stat               = '0;
      rd_stat[STA_BUSY_BIT] = busy;
   end
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
   import ecc_inj_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned CHK_W   = 8,
   parameter int unsigned REG_W   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic [REG_W-1:0]  stat_rdata,
   input  logic              wq_pending,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CHK_W-1:0]  in_check,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [CHK_W-1:0]  out_check,
   output logic              out_inj,
   output logic              out_wb
);
   localparam int unsigned MIN_REG_W = CTL_WB_BIT + 1;

   generate
      if (CHK_W < 1 || CHK_W > PAT_MAX_W) begin : g_bad_chk
         $error("CHK_W must be between 1 and the pattern field width");
      end
      if (REG_W < MIN_REG_W) begin : g_bad_reg
         $error("REG_W too narrow for the control fields");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic             ctl_armed;
   logic [CHK_W-1:0] ctl_pat;
   logic             ctl_wb;
   logic             fire;
   logic             stage_occ;
   logic             busy;

   ecc_inj_ctrl #(.REG_W(REG_W), .CHK_W(CHK_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .beat_in  (in_valid),
      .armed    (ctl_armed),
      .pat      (ctl_pat),
      .wb_en    (ctl_wb),
      .fire     (fire),
      .rd_ctl   (cfg_rdata)
   );

   ecc_inj_lane #(.DATA_W(DATA_W), .CHK_W(CHK_W), .OUT_REG(OUT_REG)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_check (in_check),
      .fire     (fire),
      .pat      (ctl_pat),
      .wb_en    (ctl_wb),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_check(out_check),
      .out_inj  (out_inj),
      .out_wb   (out_wb)
   );

   generate
      if (OUT_REG) begin : g_occ
         assign stage_occ = out_valid;
      end else begin : g_no_occ
         assign stage_occ = 1'b0;
      end
   endgenerate

   ecc_inj_busy #(.REG_W(REG_W)) u_busy (
      .wq_pending(wq_pending),
      .beat_in   (in_valid),
      .stage_occ (stage_occ),
      .busy      (busy),
      .rd_stat   (stat_rdata)
   );
endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk
   import ecc_inj_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned CHK_W   = 8,
   parameter int unsigned REG_W   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_W-1:0]  cfg_wdata,
   input logic [REG_W-1:0]  stat_rdata,
   input logic              wq_pending,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic [CHK_W-1:0]  in_check,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [CHK_W-1:0]  out_check,
   input logic              out_inj,
   input logic              out_wb,
   input logic              ctl_armed,
   input logic [CHK_W-1:0]  ctl_pat
);
   p_self_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_armed && in_valid && !cfg_we) |=> !ctl_armed);

   p_no_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[CTL_ARM_BIT]) |=> !ctl_armed);

   p_wb_only_inj_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_inj |-> !out_wb);

   generate
      if (OUT_REG) begin : g_seq
         p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wq_pending || in_valid || out_valid) |-> stat_rdata[STA_BUSY_BIT]);

         p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

         p_data_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_data == $past(in_data));

         p_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_inj |-> out_check == ($past(in_check) ^ $past(ctl_pat)));

         p_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_inj) |-> out_check == $past(in_check));

         p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_inj && !$past(cfg_we)) |=> !out_inj);
      end else begin : g_comb
         p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wq_pending || in_valid) |-> stat_rdata[STA_BUSY_BIT]);
      end
   endgenerate
endmodule

bind ecc_wr_injector ecc_inj_chk #(
   .DATA_W(DATA_W), .CHK_W(CHK_W), .REG_W(REG_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .stat_rdata(stat_rdata),
   .wq_pending(wq_pending),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .in_check  (in_check),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_check (out_check),
   .out_inj   (out_inj),
   .out_wb    (out_wb),
   .ctl_armed (ctl_armed),
   .ctl_pat   (ctl_pat)
);

// File: tb/sim_ecc_wr_injector.sv
`timescale 1ns/1ps
module sim_ecc_wr_injector;
   localparam int unsigned DATA_W = 64;
   localparam int unsigned CHK_W  = 8;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned NVEC   = 6;

   // Each vector: writeback flag, pattern, data, check byte.
   localparam logic [80:0] VEC [NVEC] = '{
      {1'b1, 8'h01, 64'h0123_4567_89AB_CDEF, 8'h5A},
      {1'b1, 8'h80, 64'hFFFF_0000_FFFF_0000, 8'h00},
      {1'b0, 8'h03, 64'hDEAD_BEEF_0BAD_F00D, 8'hC3},
      {1'b1, 8'hCE, 64'h0000_0000_0000_0001, 8'hFF},
      {1'b1, 8'h40, 64'h8000_0000_0000_0000, 8'h3C},
      {1'b0, 8'h03, 64'h5555_AAAA_5555_AAAA, 8'h00}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [REG_W-1:0]  cfg_wdata = '0;
   logic [REG_W-1:0]  cfg_rdata;
   logic [REG_W-1:0]  stat_rdata;
   logic              wq_pending = 1'b0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic [CHK_W-1:0]  in_check = '0;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;
   logic [CHK_W-1:0]  out_check;
   logic              out_inj;
   logic              out_wb;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ecc_wr_injector #(.DATA_W(DATA_W), .CHK_W(CHK_W), .REG_W(REG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata), .wq_pending(wq_pending),
      .in_valid(in_valid), .in_data(in_data), .in_check(in_check),
      .out_valid(out_valid), .out_data(out_data), .out_check(out_check),
      .out_inj(out_inj), .out_wb(out_wb)
   );

   function automatic logic [31:0] ctl(input logic wb, input logic [7:0] p, input logic arm);
      return {7'b0, wb, p, 7'b0, arm, 8'b0};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Drives one beat; on return the output stage holds it.
   task automatic beat(input logic [63:0] d, input logic [7:0] c);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_check = c;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 ctl", cfg_rdata, 0);
      check("R1 stat", stat_rdata, 0);
      check("R1 out_valid", out_valid, 0);

      // Table walk: arm, injected beat, clean beat.
      for (int i = 0; i < NVEC; i++) begin
         logic        wb;
         logic [7:0]  p;
         logic [63:0] d;
         logic [7:0]  c;
         {wb, p, d, c} = VEC[i];
         cfg_write(ctl(wb, p, 1'b1));
         check("R2 readback", cfg_rdata, ctl(wb, p, 1'b1));
         beat(d, c);
         check("R9 valid", out_valid, 1);
         check("R3 data", out_data, d);
         check("R3 check xor", out_check, c ^ p);
         check("R3 inj", out_inj, 1);
         check("R3 wb", out_wb, wb);
         if (p == 8'h03 && !wb) check("R11 ue flips", out_check ^ c, 8'h03);
         check("R4 arm cleared", cfg_rdata[8], 0);
         beat(~d, c);
         check("R4 clean after", out_check, c);
         check("R5 no inj", out_inj, 0);
         check("R5 no wb", out_wb, 0);
         @(negedge clk);
         check("R9 single valid", out_valid, 0);
      end

      // R2: junk bits read as zero
      cfg_write(32'hFFFF_FEFF);
      check("R2 junk masked", cfg_rdata, 32'h01FF_0000);

      // R8: stored but not armed
      beat(64'h1234, 8'h77);
      check("R8 unarmed check", out_check, 8'h77);
      check("R8 unarmed inj", out_inj, 0);

      // R6: back-to-back beats after arming
      cfg_write(ctl(1'b1, 8'h24, 1'b1));
      @(negedge clk);
      in_valid = 1'b1; in_data = 64'hA; in_check = 8'h10;
      @(negedge clk);
      in_data = 64'hB; in_check = 8'h20;
      check("R6 first modified", out_check, 8'h10 ^ 8'h24);
      @(negedge clk);
      in_valid = 1'b0;
      check("R6 second clean", out_check, 8'h20);
      check("R6 second no inj", out_inj, 0);

      // R10: control write in the same cycle as an armed beat
      cfg_write(ctl(1'b0, 8'h11, 1'b1));
      @(negedge clk);
      in_valid = 1'b1; in_data = 64'hC; in_check = 8'h00;
      cfg_we = 1'b1; cfg_wdata = ctl(1'b1, 8'h22, 1'b1);
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
      check("R10 old pattern", out_check, 8'h11);
      check("R10 new value kept", cfg_rdata, ctl(1'b1, 8'h22, 1'b1));
      beat(64'hD, 8'h00);
      check("R10 new pattern used", out_check, 8'h22);
      check("R10 new wb", out_wb, 1);

      // R7: busy sources
      @(negedge clk);
      @(negedge clk);
      check("R7 idle", stat_rdata, 0);
      wq_pending = 1'b1;
      #1 check("R7 queue busy", stat_rdata, 1);
      @(negedge clk);
      wq_pending = 1'b0;
      in_valid = 1'b1; in_data = 64'hE; in_check = 8'h01;
      #1 check("R7 input busy", stat_rdata, 1);
      @(negedge clk);
      in_valid = 1'b0;
      #1 check("R7 stage busy", stat_rdata, 1);
      @(negedge clk);
      #1 check("R7 drained", stat_rdata, 0);

      done = 1'b1;
      report();
      $finish;
   end
endmodule